// File: doc/BRIEF.md
# Sixteen-bit timer with compare-driven period reset

The block is a 16-bit up-counter that advances either once per clock or once per rising edge of an external count input, after that input has been brought into the clock domain. Software reaches the count through an 8-bit register bus, one byte per address. An overflow flag records each wrap from the all-ones value back to zero.

A compare unit holds a 16-bit compare value and a 4-bit mode code. When the mode selects the special-event action and the count equals the compare value, the unit raises a trigger. The trigger clears the counter, so the compare value sets the period. The trigger also sets a match flag. It never sets the overflow flag. A bus write to a count byte in the same cycle overrides the clear.

Top module: `tmr16_cmp`

## Requirements
- R1: After reset deasserts, every register reads 0: both count bytes, control, status, both compare bytes and mode. `ovf_flag_o`, `match_flag_o` and `trigger_o` are 0.
- R2: Register map, by address: 0 = count low byte, 1 = count high byte, 2 = control (bit0 run, bit1 external source, bit2 unsynchronized option), 3 = status (bit0 overflow flag, bit1 match flag), 4 = compare low byte, 5 = compare high byte, 6 = mode code in bits 3:0. With run = 1 and bit1 = 0, the count rises by one on each clock edge. With run = 0, the count holds.
- R3: With bit1 = 1, `ext_cnt_i` passes through a two-flop synchronizer and a rising-edge detector. The count then rises exactly once for each low-to-high transition of the input, and never while run = 0.
- R4: An increment from 0xFFFF wraps the count to 0x0000 and sets the overflow flag.
- R5: Writing the status address clears each flag whose data bit is 0 and leaves unchanged each flag whose data bit is 1. A set event in the same cycle wins over the clear.
- R6: A write to address 0 or 1 replaces only that byte on the next edge. The count does not also increment on that edge.
- R7: With run = 1, control bit2 = 0 and mode = 4'b1011, a count equal to the compare value drives `trigger_o` high, and the next edge loads 0 into the count. The count therefore cycles through 0 up to the compare value.
- R8: A trigger clear never sets the overflow flag, including a clear from 0xFFFF.
- R9: If a count byte write coincides with a trigger, the written byte is loaded and the clear is dropped.
- R10: With control bit2 = 1, or with any mode other than 4'b1011, no trigger occurs and the count is not cleared by a match.
- R11: Every trigger sets the match flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 3 | Register address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from the address |
| ext_cnt_i | input | 1 | External count input, asynchronous |
| trigger_o | output | 1 | Special event trigger |
| ovf_flag_o | output | 1 | Overflow flag |
| match_flag_o | output | 1 | Compare-match flag |

## Verification
A register write takes effect on the first edge after the strobe. An internal tick lands on every edge where run was already 1, so a run window opened and closed by two control writes counts the idle cycles plus one. An external rising edge reaches the count three edges after the input changes, so the bench waits five cycles before it reads. `trigger_o` is combinational on the current count, and the clear and the match flag follow on the next edge. The bench drives on the falling edge, reads shortly after it, and predicts each count with an arithmetic model that steps once per enabled edge.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 16;
  localparam int MODE_W = 4;
  localparam int ADDR_W = 3;
  localparam logic [MODE_W-1:0] MODE_SPECIAL = 4'b1011;

  typedef enum logic [ADDR_W-1:0] {
    A_CNT_LO = 3'd0,
    A_CNT_HI = 3'd1,
    A_CTRL   = 3'd2,
    A_STAT   = 3'd3,
    A_CMP_LO = 3'd4,
    A_CMP_HI = 3'd5,
    A_MODE   = 3'd6
  } reg_addr_e;

  typedef struct packed {
    logic no_sync;
    logic ext_src;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/tmr16_edge_sync.sv
module tmr16_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [CNT_W/BYTE_W-1:0] byte_we_i,
  input  logic [BYTE_W-1:0]      wdata_i,
  input  logic                   tick_i,
  input  logic                   clear_i,
  output logic [CNT_W-1:0]       count_o,
  output logic                   wrap_o
);
  localparam int NB = CNT_W / BYTE_W;

  logic [CNT_W-1:0] count_q, count_d;

  // write beats clear, clear beats tick
  always_comb begin
    count_d = count_q;
    if (|byte_we_i) begin
      for (int l = 0; l < NB; l++)
        if (byte_we_i[l]) count_d[l*BYTE_W +: BYTE_W] = wdata_i;
    end else if (clear_i) begin
      count_d = '0;
    end else if (tick_i) begin
      count_d = count_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else         count_q <= count_d;
  end

  assign count_o = count_q;
  assign wrap_o  = tick_i & ~clear_i & ~(|byte_we_i) & (&count_q);
endmodule

// File: rtl/tmr16_compare.sv
module tmr16_compare
  import tmr16_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [CNT_W/BYTE_W-1:0] cmp_we_i,
  input  logic                    mode_we_i,
  input  logic [BYTE_W-1:0]       wdata_i,
  input  logic [CNT_W-1:0]        count_i,
  input  logic                    arm_i,
  output logic [CNT_W-1:0]        cmp_o,
  output logic [MODE_W-1:0]       mode_o,
  output logic                    trigger_o
);
  localparam int NB = CNT_W / BYTE_W;

  logic [CNT_W-1:0]  cmp_q;
  logic [MODE_W-1:0] mode_q;

  for (genvar l = 0; l < NB; l++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          cmp_q[l*BYTE_W +: BYTE_W] <= '0;
      else if (cmp_we_i[l]) cmp_q[l*BYTE_W +: BYTE_W] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= '0;
    else if (mode_we_i) mode_q <= wdata_i[MODE_W-1:0];
  end

  assign cmp_o     = cmp_q;
  assign mode_o    = mode_q;
  assign trigger_o = arm_i & (mode_q == MODE_SPECIAL) & (count_i == cmp_q);
endmodule

// File: rtl/tmr16_cmp.sv
module tmr16_cmp
  import tmr16_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [BYTE_W-1:0] bus_wdata_i,
  output logic [BYTE_W-1:0] bus_rdata_o,
  input  logic              ext_cnt_i,
  output logic              trigger_o,
  output logic              ovf_flag_o,
  output logic              match_flag_o
);
  ctrl_t              ctrl_q;
  logic [1:0]         flag_q;
  logic [1:0]         cnt_we, cmp_we;
  logic               ctrl_we, stat_we, mode_we;
  logic               ext_rise, tick, wrap, trig;
  logic [CNT_W-1:0]   count_q, cmp_val;
  logic [MODE_W-1:0]  mode_val;
  logic [1:0]         flag_set, flag_keep;

  assign cnt_we  = {bus_we_i && bus_addr_i == A_CNT_HI, bus_we_i && bus_addr_i == A_CNT_LO};
  assign cmp_we  = {bus_we_i && bus_addr_i == A_CMP_HI, bus_we_i && bus_addr_i == A_CMP_LO};
  assign ctrl_we = bus_we_i && bus_addr_i == A_CTRL;
  assign stat_we = bus_we_i && bus_addr_i == A_STAT;
  assign mode_we = bus_we_i && bus_addr_i == A_MODE;

  tmr16_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(ext_cnt_i),
    .rise_o (ext_rise)
  );

  assign tick = ctrl_q.run & (ctrl_q.ext_src ? ext_rise : 1'b1);

  tmr16_counter #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .byte_we_i(cnt_we),
    .wdata_i  (bus_wdata_i),
    .tick_i   (tick),
    .clear_i  (trig),
    .count_o  (count_q),
    .wrap_o   (wrap)
  );

  tmr16_compare #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_cmp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmp_we_i (cmp_we),
    .mode_we_i(mode_we),
    .wdata_i  (bus_wdata_i),
    .count_i  (count_q),
    .arm_i    (ctrl_q.run & ~ctrl_q.no_sync),
    .cmp_o    (cmp_val),
    .mode_o   (mode_val),
    .trigger_o(trig)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_t'(bus_wdata_i[2:0]);
  end

  // write-0-to-clear; a set in the same cycle wins
  assign flag_set  = {trig, wrap};
  assign flag_keep = stat_we ? bus_wdata_i[1:0] : 2'b11;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & flag_keep) | flag_set;
  end

  always_comb begin
    unique case (bus_addr_i)
      A_CNT_LO: bus_rdata_o = count_q[7:0];
      A_CNT_HI: bus_rdata_o = count_q[15:8];
      A_CTRL:   bus_rdata_o = {5'd0, ctrl_q};
      A_STAT:   bus_rdata_o = {6'd0, flag_q};
      A_CMP_LO: bus_rdata_o = cmp_val[7:0];
      A_CMP_HI: bus_rdata_o = cmp_val[15:8];
      A_MODE:   bus_rdata_o = {4'd0, mode_val};
      default:  bus_rdata_o = '0;
    endcase
  end

  assign trigger_o    = trig;
  assign ovf_flag_o   = flag_q[0];
  assign match_flag_o = flag_q[1];
endmodule

// File: rtl/tmr16_cmp_chk.sv
module tmr16_cmp_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        trigger_i,
  input logic        ovf_i,
  input logic        match_i,
  input logic [15:0] count_i,
  input logic        run_i,
  input logic        no_sync_i,
  input logic [1:0]  cnt_we_i,
  input logic [7:0]  wdata_i,
  input logic        tick_i
);
  AST_HOLD_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && cnt_we_i == 2'b00) |=> $stable(count_i)); // R2
  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && count_i == 16'hFFFF && !trigger_i && cnt_we_i == 2'b00) |=> ovf_i); // R4
  AST_TRIG_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trigger_i && cnt_we_i == 2'b00) |=> count_i == 16'h0000); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trigger_i && !ovf_i) |=> !ovf_i); // R8
  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i[0] |=> count_i[7:0] == $past(wdata_i)); // R9
  AST_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_sync_i |-> !trigger_i); // R10
  AST_MATCH_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trigger_i |=> match_i); // R11
endmodule

bind tmr16_cmp tmr16_cmp_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .trigger_i(trigger_o),
  .ovf_i    (ovf_flag_o),
  .match_i  (match_flag_o),
  .count_i  (count_q),
  .run_i    (ctrl_q.run),
  .no_sync_i(ctrl_q.no_sync),
  .cnt_we_i (cnt_we),
  .wdata_i  (bus_wdata_i),
  .tick_i   (tick)
);

// File: tb/tmr16_cmp_tb_top.sv
`timescale 1ns/1ps
module tmr16_cmp_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ext = 1'b0;
  logic       trig, ovf, match;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tmr16_cmp dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .ext_cnt_i(ext),
    .trigger_o(trig), .ovf_flag_o(ovf), .match_flag_o(match)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called just after a falling edge; consumes one rising edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(3'd0, lo); rd(3'd1, hi); v = {hi, lo};
  endtask

  task automatic set16(input logic [2:0] a, input logic [15:0] v);
    wr(a, v[7:0]); wr(a + 3'd1, v[15:8]);
  endtask

  // run for n idle cycles between enable and disable: n+1 enabled edges
  task automatic run_model(input logic [15:0] start, input logic [15:0] cmpv, input bit special,
                           input int n, output logic [15:0] c, output bit m, output bit o);
    c = start; m = 0; o = 0;
    for (int i = 0; i <= n; i++) begin
      if (special && c == cmpv) begin c = 16'h0; m = 1; end
      else begin if (c == 16'hFFFF) o = 1; c = c + 16'h1; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v, expc;
    bit          em, eo;
    logic [15:0] starts [4] = '{16'h0000, 16'h00FE, 16'hFFFE, 16'h1234};
    int          lens   [3] = '{0, 3, 17};
    logic [15:0] cmps   [3] = '{16'd0, 16'd3, 16'd9};

    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), b); check("R1 reg", {24'd0, b}, 32'd0);
    end
    check("R1 flags", {29'd0, trig, ovf, match}, 32'd0);

    // R2 R4 internal count sweep
    foreach (starts[s]) foreach (lens[k]) begin
      wr(3'd3, 8'h00);
      set16(3'd0, starts[s]);
      wr(3'd2, 8'h01); idle(lens[k]); wr(3'd2, 8'h00);
      run_model(starts[s], 16'h0, 0, lens[k], expc, em, eo);
      rd16(v);
      check("R2 count", {16'd0, v}, {16'd0, expc});
      check("R4 overflow flag", {31'd0, ovf}, {31'd0, eo});
    end

    // R5 flag clearing
    wr(3'd3, 8'h00); set16(3'd0, 16'hFFFF); wr(3'd2, 8'h01); wr(3'd2, 8'h00);
    check("R4 set at wrap", {31'd0, ovf}, 32'd1);
    wr(3'd3, 8'h01);
    check("R5 write 1 keeps", {31'd0, ovf}, 32'd1);
    wr(3'd3, 8'h02);
    check("R5 write 0 clears", {31'd0, ovf}, 32'd0);
    wr(3'd3, 8'hFF);
    check("R5 write 1 no set", {30'd0, match, ovf}, 32'd0);

    // R7 R11 special event sweep
    wr(3'd6, 8'h0B);
    foreach (cmps[k]) begin
      wr(3'd3, 8'h00); set16(3'd4, cmps[k]); set16(3'd0, 16'h0);
      wr(3'd2, 8'h01); idle(25); wr(3'd2, 8'h00);
      run_model(16'h0, cmps[k], 1, 25, expc, em, eo);
      rd16(v);
      check("R7 period count", {16'd0, v}, {16'd0, expc});
      check("R11 match flag", {31'd0, match}, {31'd0, em});
    end

    // R8 clear from FFFF without overflow
    wr(3'd3, 8'h00); set16(3'd4, 16'hFFFF); set16(3'd0, 16'hFFFD);
    wr(3'd2, 8'h01); idle(4); wr(3'd2, 8'h00);
    rd16(v);
    check("R8 count", {16'd0, v}, 32'h0002);
    check("R8 no overflow", {31'd0, ovf}, 32'd0);
    check("R11 match", {31'd0, match}, 32'd1);

    // R10 other mode
    wr(3'd3, 8'h00); set16(3'd4, 16'd3); wr(3'd6, 8'h0A); set16(3'd0, 16'h0);
    wr(3'd2, 8'h01); idle(10); wr(3'd2, 8'h00);
    rd16(v);
    check("R10 mode 1010 count", {16'd0, v}, 32'd11);
    check("R10 mode 1010 match", {31'd0, match}, 32'd0);

    // R10 unsynchronized option
    wr(3'd6, 8'h0B); set16(3'd0, 16'h0);
    wr(3'd2, 8'h05); idle(10); wr(3'd2, 8'h00);
    rd16(v);
    check("R10 no_sync count", {16'd0, v}, 32'd11);
    check("R10 no_sync match", {31'd0, match}, 32'd0);

    // R9 write wins over trigger
    wr(3'd3, 8'h00); set16(3'd4, 16'd5); set16(3'd0, 16'd5);
    wr(3'd2, 8'h01);
    #1 check("R7 trigger visible", {31'd0, trig}, 32'd1);
    wr(3'd0, 8'h22);
    rd16(v);
    check("R9 written value", {16'd0, v}, 32'h0022);
    check("R11 match on collision", {31'd0, match}, 32'd1);
    wr(3'd2, 8'h00);

    // R6 byte write, no increment
    wr(3'd6, 8'h00); set16(3'd0, 16'h0040);
    wr(3'd2, 8'h01); wr(3'd1, 8'h12);
    rd16(v);
    check("R6 byte replace", {16'd0, v}, 32'h1240);
    wr(3'd2, 8'h00);
    rd16(v);
    check("R6 resumes", {16'd0, v}, 32'h1241);
    idle(10);
    rd16(v);
    check("R2 hold disabled", {16'd0, v}, 32'h1241);

    // R3 external edges
    for (int p = 1; p <= 4; p += 3) begin
      set16(3'd0, 16'h0);
      wr(3'd2, 8'h03);
      for (int i = 0; i < p * 2; i++) begin ext = 1'b1; idle(2); ext = 1'b0; idle(3); end
      idle(5);
      wr(3'd2, 8'h00);
      rd16(v);
      check("R3 ext count", {16'd0, v}, 32'(p * 2));
    end
    for (int i = 0; i < 3; i++) begin ext = 1'b1; idle(2); ext = 1'b0; idle(2); end
    idle(5);
    rd16(v);
    check("R3 ext while stopped", {16'd0, v}, 32'd8);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule